// File: doc/BRIEF.md
# Prescaled 16-bit Down-Counter Timer Channel

This block is one channel of a timer bank. It holds a reload value, a control byte, a one-bit test register and a 16-bit count, all reachable through a simple register port qualified by a channel select, an access-phase strobe and a write flag. The count moves down by one on each internal count enable. That enable is one of three externally generated tick pulses (every cycle, every 16th, every 256th), picked by a prescale field and gated by a run bit.

The count is held as four 4-bit nibbles. Each nibble decrements when the nibble below it borrows. A test bit makes every nibble step on every count enable. When the count reaches zero, a sticky interrupt is raised. From zero, the next count enable either wraps the count to 0xFFFF (free-running) or reloads the stored reload value (periodic). The interrupt stays high until the clear location is written. Read data for the addressed location is presented combinationally, so that a shared bus multiplexer outside the block can select it.

Top module: `tmr16_channel`

## Requirements
- R1: A register write happens only in a cycle where `sel`, `en_phase` and `wr` are all high. In any other cycle, the reload, control and test registers and the count keep their values.
- R2: After reset, the reload value and the count read 0xFFFF, and the control byte, the test bit and `irq` are all 0.
- R3: The word addresses are: 0 reload (read/write), 1 count (read only), 2 control, 3 interrupt clear (write only, reads 0), 4 test. Addresses 5 to 7 read 0. Control reads as {reload[15:8], control byte}. Test reads as {reload[15:1], test bit}.
- R4: A write to address 0 stores the data as the reload value. At the same clock edge it places the data in the count, whatever the run bit and the ticks are doing. Loading a value, zero included, never sets `irq`.
- R5: The control byte has the run bit at bit 7, periodic mode at bit 6 and prescale at bits [3:2]. Prescale 00 selects `tick_div1`, 01 selects `tick_div16`, and 10 or 11 selects `tick_div256`. The count moves only when the run bit is high and the selected tick is high in the same cycle.
- R6: Outside test mode, each count enable lowers the count by exactly one, with the borrow passed across nibbles (for example 0x0100 becomes 0x00FF).
- R7: Outside periodic mode, a count enable at count 0 gives 0xFFFF and does not set `irq`.
- R8: In periodic mode, a count enable at count 0 loads the reload value into the count.
- R9: When test bit 0 is set, every nibble decrements on each count enable (0x1234 becomes 0x0123, and then 0xF012).
- R10: `irq` rises in the cycle after a count enable that brings the count to 0. It stays high until it is cleared.
- R11: A write of any data to address 3 clears `irq`. If a new zero event occurs in the same cycle, `irq` stays set.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Register and counter clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| sel | input | 1 | Channel select from the shared decoder |
| en_phase | input | 1 | Access phase strobe |
| wr | input | 1 | High for a write access |
| addr | input | 3 | Word address |
| wdata | input | 16 | Write data |
| tick_div1 | input | 1 | Tick pulse, every cycle rate |
| tick_div16 | input | 1 | Tick pulse, one in 16 |
| tick_div256 | input | 1 | Tick pulse, one in 256 |
| irq | output | 1 | Sticky zero-reached interrupt |
| rdata | output | 16 | Read data for the addressed location |

## Verification
Two pairs of functions can fall in the same cycle. The first pair is a clear write and a count enable that takes the count from 1 to 0. The bench drives the clear access and a divide-by-1 tick in one cycle and expects `irq` to stay high while the count reads 0. The second pair is a reload write and a tick. The bench drives both together and expects the count to hold exactly the written data rather than one less.

// File: rtl/tmr16_pkg.sv
package tmr16_pkg;
  localparam int ADDR_W = 3;

  typedef enum logic [ADDR_W-1:0] {
    A_LOAD  = 3'd0,
    A_VALUE = 3'd1,
    A_CTRL  = 3'd2,
    A_CLEAR = 3'd3,
    A_TEST  = 3'd4
  } tmr_addr_e;

  typedef enum logic [1:0] {
    PS_DIV1   = 2'b00,
    PS_DIV16  = 2'b01,
    PS_DIV256 = 2'b10,
    PS_RSVD   = 2'b11
  } prescale_e;

  typedef struct packed {
    logic      run;
    logic      periodic;
    prescale_e ps;
  } ctrl_t;

  localparam int CTL_RUN_BIT = 7;
  localparam int CTL_PER_BIT = 6;
  localparam int CTL_PS_LO   = 2;
  localparam int CTL_BYTE_W  = 8;
endpackage

// File: rtl/tmr16_regfile.sv
module tmr16_regfile
  import tmr16_pkg::*;
#(
  parameter int DATA_W = 16
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic                sel,
  input  logic                en_phase,
  input  logic                wr,
  input  logic [ADDR_W-1:0]   addr,
  input  logic [DATA_W-1:0]   wdata,
  output ctrl_t               ctrl_q,
  output logic                test_q,
  output logic [DATA_W-1:0]   load_q,
  output logic                load_wr,
  output logic                clear_wr
);
  logic wr_acc;
  logic ctrl_wr;
  logic test_wr;

  assign wr_acc   = sel & en_phase & wr;
  assign load_wr  = wr_acc & (addr == A_LOAD);
  assign ctrl_wr  = wr_acc & (addr == A_CTRL);
  assign clear_wr = wr_acc & (addr == A_CLEAR);
  assign test_wr  = wr_acc & (addr == A_TEST);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ctrl_q <= '0;
      test_q <= 1'b0;
      load_q <= '1;
    end else begin
      if (ctrl_wr) begin
        ctrl_q.run      <= wdata[CTL_RUN_BIT];
        ctrl_q.periodic <= wdata[CTL_PER_BIT];
        ctrl_q.ps       <= prescale_e'(wdata[CTL_PS_LO +: 2]);
      end
      if (test_wr) test_q <= wdata[0];
      if (load_wr) load_q <= wdata;
    end
  end
endmodule

// File: rtl/tmr16_tick_sel.sv
module tmr16_tick_sel
  import tmr16_pkg::*;
(
  input  logic      tick_div1,
  input  logic      tick_div16,
  input  logic      tick_div256,
  input  logic      run,
  input  prescale_e ps,
  output logic      count_en
);
  logic tick_pick;

  always_comb begin
    unique case (ps)
      PS_DIV1:  tick_pick = tick_div1;
      PS_DIV16: tick_pick = tick_div16;
      default:  tick_pick = tick_div256;
    endcase
  end

  assign count_en = run & tick_pick;
endmodule

// File: rtl/tmr16_nibble.sv
module tmr16_nibble #(
  parameter int W = 4
) (
  input  logic [W-1:0] q,
  input  logic         en,
  output logic [W-1:0] nxt,
  output logic         borrow,
  output logic         zero_next
);
  localparam logic [W-1:0] ONE = W'(1);

  assign nxt       = en ? (q - ONE) : q;
  assign borrow    = (q == '0);
  assign zero_next = en ? (q == ONE) : (q == '0);
endmodule

// File: rtl/tmr16_counter.sv
module tmr16_counter #(
  parameter int CNT_W = 16,
  parameter int NIB_W = 4
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             count_en,
  input  logic             test_mode,
  input  logic             periodic,
  input  logic             load_wr,
  input  logic [CNT_W-1:0] load_data,
  input  logic [CNT_W-1:0] reload_val,
  output logic [CNT_W-1:0] value,
  output logic             hit_zero
);
  localparam int NUM_NIB = CNT_W / NIB_W;

  logic [NUM_NIB:0]   en_chain;
  logic [NUM_NIB:0]   zero_chain;
  logic [CNT_W-1:0]   dec_value;
  logic               reload;

  assign en_chain[0]   = count_en;
  assign zero_chain[0] = 1'b1;

  for (genvar i = 0; i < NUM_NIB; i++) begin : g_nib
    logic b_i;
    logic z_i;
    tmr16_nibble #(.W(NIB_W)) u_nib (
      .q        (value[i*NIB_W +: NIB_W]),
      .en       (en_chain[i]),
      .nxt      (dec_value[i*NIB_W +: NIB_W]),
      .borrow   (b_i),
      .zero_next(z_i)
    );
    assign en_chain[i+1]   = test_mode ? count_en : (en_chain[i] & b_i);
    assign zero_chain[i+1] = zero_chain[i] & z_i;
  end

  assign reload   = count_en & periodic & (value == '0);
  assign hit_zero = count_en & ~load_wr & ~reload & zero_chain[NUM_NIB];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      value <= '1;
    end else if (load_wr) begin
      value <= load_data;
    end else if (reload) begin
      value <= reload_val;
    end else if (count_en) begin
      value <= dec_value;
    end
  end
endmodule

// File: rtl/tmr16_irq.sv
module tmr16_irq (
  input  logic clk,
  input  logic rst_n,
  input  logic set,
  input  logic clr,
  output logic irq_q
);
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)   irq_q <= 1'b0;
    else if (set) irq_q <= 1'b1;
    else if (clr) irq_q <= 1'b0;
  end
endmodule

// File: rtl/tmr16_rdmux.sv
module tmr16_rdmux
  import tmr16_pkg::*;
#(
  parameter int DATA_W = 16
) (
  input  logic [ADDR_W-1:0] addr,
  input  ctrl_t             ctrl_q,
  input  logic              test_q,
  input  logic [DATA_W-1:0] load_q,
  input  logic [DATA_W-1:0] value,
  output logic [DATA_W-1:0] rdata
);
  logic [CTL_BYTE_W-1:0] ctrl_byte;

  always_comb begin
    ctrl_byte                  = '0;
    ctrl_byte[CTL_RUN_BIT]     = ctrl_q.run;
    ctrl_byte[CTL_PER_BIT]     = ctrl_q.periodic;
    ctrl_byte[CTL_PS_LO +: 2]  = ctrl_q.ps;
  end

  always_comb begin
    unique case (addr)
      A_LOAD:  rdata = load_q;
      A_VALUE: rdata = value;
      A_CTRL:  rdata = {load_q[DATA_W-1:CTL_BYTE_W], ctrl_byte};
      A_TEST:  rdata = {load_q[DATA_W-1:1], test_q};
      default: rdata = '0;
    endcase
  end
endmodule

// File: rtl/tmr16_channel.sv
module tmr16_channel
  import tmr16_pkg::*;
#(
  parameter int DATA_W = 16,
  parameter int NIB_W  = 4
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              sel,
  input  logic              en_phase,
  input  logic              wr,
  input  logic [ADDR_W-1:0] addr,
  input  logic [DATA_W-1:0] wdata,
  input  logic              tick_div1,
  input  logic              tick_div16,
  input  logic              tick_div256,
  output logic              irq,
  output logic [DATA_W-1:0] rdata
);
  ctrl_t             ctrl_q;
  logic              test_q;
  logic [DATA_W-1:0] load_q;
  logic              load_wr;
  logic              clear_wr;
  logic              count_en;
  logic [DATA_W-1:0] cnt_value;
  logic              hit_zero;
  logic              run_q;
  logic              periodic_q;

  assign run_q      = ctrl_q.run;
  assign periodic_q = ctrl_q.periodic;

  tmr16_regfile #(.DATA_W(DATA_W)) u_regs (
    .clk     (clk),
    .rst_n   (rst_n),
    .sel     (sel),
    .en_phase(en_phase),
    .wr      (wr),
    .addr    (addr),
    .wdata   (wdata),
    .ctrl_q  (ctrl_q),
    .test_q  (test_q),
    .load_q  (load_q),
    .load_wr (load_wr),
    .clear_wr(clear_wr)
  );

  tmr16_tick_sel u_tick (
    .tick_div1  (tick_div1),
    .tick_div16 (tick_div16),
    .tick_div256(tick_div256),
    .run        (run_q),
    .ps         (ctrl_q.ps),
    .count_en   (count_en)
  );

  tmr16_counter #(.CNT_W(DATA_W), .NIB_W(NIB_W)) u_cnt (
    .clk       (clk),
    .rst_n     (rst_n),
    .count_en  (count_en),
    .test_mode (test_q),
    .periodic  (periodic_q),
    .load_wr   (load_wr),
    .load_data (wdata),
    .reload_val(load_q),
    .value     (cnt_value),
    .hit_zero  (hit_zero)
  );

  tmr16_irq u_irq (
    .clk  (clk),
    .rst_n(rst_n),
    .set  (hit_zero),
    .clr  (clear_wr),
    .irq_q(irq)
  );

  tmr16_rdmux #(.DATA_W(DATA_W)) u_rd (
    .addr  (addr),
    .ctrl_q(ctrl_q),
    .test_q(test_q),
    .load_q(load_q),
    .value (cnt_value),
    .rdata (rdata)
  );
endmodule

// File: rtl/tmr16_channel_checker.sv
module tmr16_channel_checker #(
  parameter int DATA_W = 16
) (
  input logic              clk,
  input logic              rst_n,
  input logic              sel,
  input logic              en_phase,
  input logic              wr,
  input logic [2:0]        addr,
  input logic [DATA_W-1:0] wdata,
  input logic              irq,
  input logic [DATA_W-1:0] value,
  input logic [DATA_W-1:0] load_val,
  input logic              count_en,
  input logic              periodic,
  input logic              test_mode
);
  logic acc, ld, clr, one_to_zero;
  assign acc = sel && en_phase && wr;
  assign ld  = acc && (addr == 3'd0);
  assign clr = acc && (addr == 3'd3);
  assign one_to_zero = count_en && !ld && !test_mode && (value == DATA_W'(1));

  assert_no_write_R1: assert property (@(posedge clk) disable iff (!rst_n)
    !acc |=> $stable(load_val));

  assert_load_force_R4: assert property (@(posedge clk) disable iff (!rst_n)
    ld |=> value == $past(wdata));

  assert_hold_R5: assert property (@(posedge clk) disable iff (!rst_n)
    !count_en && !ld |=> $stable(value));

  assert_step_R6: assert property (@(posedge clk) disable iff (!rst_n)
    count_en && !ld && !test_mode && value != '0 |=> value == $past(value) - DATA_W'(1));

  assert_wrap_R7: assert property (@(posedge clk) disable iff (!rst_n)
    count_en && !ld && !periodic && value == '0 |=> value == '1);

  assert_reload_R8: assert property (@(posedge clk) disable iff (!rst_n)
    count_en && !ld && periodic && value == '0 |=> value == $past(load_val));

  assert_set_R10: assert property (@(posedge clk) disable iff (!rst_n)
    one_to_zero |=> irq);

  assert_sticky_R10: assert property (@(posedge clk) disable iff (!rst_n)
    irq && !clr |=> irq);

  assert_clear_R11: assert property (@(posedge clk) disable iff (!rst_n)
    clr && !test_mode && !one_to_zero |=> !irq);
endmodule

bind tmr16_channel tmr16_channel_checker #(.DATA_W(DATA_W)) u_chk (
  .clk      (clk),
  .rst_n    (rst_n),
  .sel      (sel),
  .en_phase (en_phase),
  .wr       (wr),
  .addr     (addr),
  .wdata    (wdata),
  .irq      (irq),
  .value    (cnt_value),
  .load_val (load_q),
  .count_en (count_en),
  .periodic (periodic_q),
  .test_mode(test_q)
);

// File: tb/tmr16_channel_bench.sv
module tmr16_channel_bench;
  localparam int CLK_PERIOD = 10;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        sel = 1'b0, en_phase = 1'b0, wr = 1'b0;
  logic [2:0]  addr = 3'd0;
  logic [15:0] wdata = 16'h0;
  logic [2:0]  ticks = 3'b000;
  logic        irq;
  logic [15:0] rdata;

  int checks = 0;
  int errors = 0;
  bit done = 1'b0;

  typedef struct {
    bit          is_irq;
    logic [15:0] exp;
    string       tag;
  } item_t;
  item_t sbq[$];

  always #(CLK_PERIOD/2) clk = ~clk;

  tmr16_channel u_tmr16_channel (
    .clk(clk), .rst_n(rst_n), .sel(sel), .en_phase(en_phase), .wr(wr),
    .addr(addr), .wdata(wdata),
    .tick_div1(ticks[0]), .tick_div16(ticks[1]), .tick_div256(ticks[2]),
    .irq(irq), .rdata(rdata)
  );

  // monitor: pops expected items and compares at the falling edge
  initial begin
    item_t it;
    logic [15:0] act;
    forever begin
      @(negedge clk);
      if (sbq.size() > 0) begin
        it = sbq.pop_front();
        act = it.is_irq ? {15'b0, irq} : rdata;
        checks++;
        if (act !== it.exp) begin
          errors++;
          $display("FAIL %s actual=%h expected=%h", it.tag, act, it.exp);
        end
      end
    end
  end

  task automatic cyc(input logic s, input logic e, input logic w,
                     input logic [2:0] a, input logic [15:0] d, input logic [2:0] t);
    @(posedge clk); #1;
    sel = s; en_phase = e; wr = w; addr = a; wdata = d; ticks = t;
    @(posedge clk); #1;
    sel = 0; en_phase = 0; wr = 0; wdata = 16'h0; ticks = 3'b000;
  endtask

  task automatic wreg(input logic [2:0] a, input logic [15:0] d);
    cyc(1, 1, 1, a, d, 3'b000);
  endtask

  task automatic tick(input logic [2:0] t);
    cyc(0, 0, 0, 3'd0, 16'h0, t);
  endtask

  task automatic exp_rd(input logic [2:0] a, input logic [15:0] e, input string tag);
    item_t it;
    @(posedge clk); #1;
    addr = a;
    it.is_irq = 1'b0; it.exp = e; it.tag = tag;
    sbq.push_back(it);
    @(negedge clk); #1;
  endtask

  task automatic exp_irq(input logic e, input string tag);
    item_t it;
    @(posedge clk); #1;
    it.is_irq = 1'b1; it.exp = {15'b0, e}; it.tag = tag;
    sbq.push_back(it);
    @(negedge clk); #1;
  endtask

  initial begin
    #(CLK_PERIOD * 150000);
    if (!done) begin
      errors++;
      $display("FAIL watchdog actual=hung expected=finished");
      $display("  CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  initial begin
    repeat (3) @(posedge clk);
    #1 rst_n = 1'b1;

    // R2 / R3 reset state and map
    exp_rd(3'd0, 16'hFFFF, "R2 reload reset");
    exp_rd(3'd1, 16'hFFFF, "R2 count reset");
    exp_rd(3'd2, 16'hFF00, "R2 R3 control reset padded");
    exp_rd(3'd4, 16'hFFFE, "R2 R3 test reset padded");
    exp_rd(3'd3, 16'h0000, "R3 clear reads zero");
    exp_irq(1'b0, "R2 irq reset");

    // R1 write qualification
    cyc(0, 1, 1, 3'd0, 16'h1234, 3'b000);
    cyc(1, 0, 1, 3'd0, 16'h1234, 3'b000);
    cyc(1, 1, 0, 3'd0, 16'h1234, 3'b000);
    exp_rd(3'd0, 16'hFFFF, "R1 unqualified write ignored");
    exp_rd(3'd1, 16'hFFFF, "R1 count untouched");

    // R4 load forces count
    wreg(3'd0, 16'h0003);
    exp_rd(3'd1, 16'h0003, "R4 load into count");
    exp_rd(3'd2, 16'h0000, "R3 control padding from reload");
    exp_rd(3'd4, 16'h0002, "R3 test padding from reload");

    // R5 prescale /16, run
    wreg(3'd2, 16'h0084);
    exp_rd(3'd2, 16'h0084, "R5 control readback");
    tick(3'b001);
    exp_rd(3'd1, 16'h0003, "R5 wrong tick ignored");
    tick(3'b010);
    exp_rd(3'd1, 16'h0002, "R5 div16 tick counts");
    tick(3'b100);
    exp_rd(3'd1, 16'h0002, "R5 div256 tick ignored");
    tick(3'b010);
    tick(3'b010);
    exp_rd(3'd1, 16'h0000, "R6 reached zero");
    exp_irq(1'b1, "R10 irq on zero");
    tick(3'b010);
    exp_rd(3'd1, 16'hFFFF, "R7 free wrap");
    exp_irq(1'b1, "R10 irq sticky");
    wreg(3'd3, 16'hABCD);
    exp_irq(1'b0, "R11 clear");

    // R6 borrow across nibbles
    wreg(3'd0, 16'h0100);
    wreg(3'd2, 16'h0080);
    tick(3'b001);
    exp_rd(3'd1, 16'h00FF, "R6 borrow across nibbles");
    tick(3'b001);
    exp_rd(3'd1, 16'h00FE, "R6 next step");

    // R5 reserved prescale -> /256
    wreg(3'd2, 16'h008C);
    tick(3'b100);
    exp_rd(3'd1, 16'h00FD, "R5 prescale 11 uses div256");
    tick(3'b001);
    exp_rd(3'd1, 16'h00FD, "R5 prescale 11 ignores div1");

    // R5 run bit off
    wreg(3'd2, 16'h0000);
    tick(3'b111);
    exp_rd(3'd1, 16'h00FD, "R5 run off holds");

    // R8 periodic
    wreg(3'd0, 16'h0002);
    wreg(3'd2, 16'h00C0);
    tick(3'b001);
    tick(3'b001);
    exp_rd(3'd1, 16'h0000, "R8 periodic reaches zero");
    exp_irq(1'b1, "R10 periodic zero irq");
    tick(3'b001);
    exp_rd(3'd1, 16'h0002, "R8 periodic reload");
    exp_irq(1'b1, "R10 still set after reload");
    wreg(3'd3, 16'h0000);
    exp_irq(1'b0, "R11 clear after periodic");

    // R11 set wins over clear in same cycle
    tick(3'b001);
    exp_rd(3'd1, 16'h0001, "R8 count to one");
    cyc(1, 1, 1, 3'd3, 16'h0000, 3'b001);
    exp_rd(3'd1, 16'h0000, "R11 zero in collision cycle");
    exp_irq(1'b1, "R11 set wins over clear");

    // R9 test mode
    wreg(3'd2, 16'h0080);
    wreg(3'd3, 16'h0000);
    wreg(3'd4, 16'h0001);
    wreg(3'd0, 16'h1234);
    exp_rd(3'd4, 16'h1235, "R9 R3 test readback");
    tick(3'b001);
    exp_rd(3'd1, 16'h0123, "R9 all nibbles step");
    tick(3'b001);
    exp_rd(3'd1, 16'hF012, "R9 all nibbles wrap");
    exp_irq(1'b0, "R9 no irq without zero");
    wreg(3'd0, 16'h1111);
    tick(3'b001);
    exp_rd(3'd1, 16'h0000, "R9 test mode to zero");
    exp_irq(1'b1, "R10 irq in test mode");
    wreg(3'd4, 16'h0000);
    exp_rd(3'd4, 16'h1110, "R9 test mode off");
    wreg(3'd3, 16'h0000);

    // R4 load beats tick
    cyc(1, 1, 1, 3'd0, 16'h0050, 3'b001);
    exp_rd(3'd1, 16'h0050, "R4 load wins over tick");
    exp_irq(1'b0, "R4 load no irq");

    // R3 count read only, unmapped reads
    wreg(3'd1, 16'h1111);
    exp_rd(3'd1, 16'h0050, "R3 count read only");
    exp_rd(3'd5, 16'h0000, "R3 addr5 zero");
    exp_rd(3'd7, 16'h0000, "R3 addr7 zero");

    // R4 load zero: no irq; R7 wrap from zero no irq
    wreg(3'd0, 16'h0000);
    exp_rd(3'd1, 16'h0000, "R4 load zero");
    exp_irq(1'b0, "R4 load zero no irq");
    tick(3'b001);
    exp_rd(3'd1, 16'hFFFF, "R7 wrap from loaded zero");
    exp_irq(1'b0, "R7 wrap no irq");

    @(posedge clk);
    @(negedge clk);
    done = 1'b1;
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule